// File: doc/BRIEF.md
# Receive Flow-Control Character Detector

This block sits between a UART receiver and its receive FIFO. Each time the receiver completes a character, the block compares it with four programmable match registers. These are two resume characters and two pause characters. When a software flow-control sequence is found, the block raises a one-cycle request toward the transmitter: pause on a pause sequence, resume on a resume sequence. The characters that make up that sequence are removed from the stream. Every other character is passed to the FIFO write port unchanged.

A 4-bit control field picks the matching style for each direction:
- off;
- a single character equal to the first register of the pair;
- a single character equal to the second register of the pair;
- a two-character sequence, first register then second register.

In the two-character style, a first byte that matches is held back until the next byte arrives. If that next byte completes the pair, both are dropped. If it does not, the held byte goes to the FIFO, and the breaking byte is judged again from scratch.

A separate special-character mode compares every byte with the second pause register. On a match it sets a sticky interrupt flag and still stores the byte. The host clears the flag by reading the interrupt status.

Top module: `rxfc_detect`

## Requirements
- R1: After reset all four match registers and the control field are zero and every feature is off. A received character is then written to the FIFO unchanged one cycle after its strobe, with no pause or resume pulse and the special flag low.
- R2: A write with address 0, 1, 2 or 3 loads resume-1, resume-2, pause-1 or pause-2. Address 4 loads the control field:
  - bits [1:0] are the resume mode;
  - bits [3:2] are the pause mode;
  - bit 4 is the special-character enable.
  Bit 0 of every match register is compared with the least significant bit of the character.
- R3: The mode encoding for each direction is: 0 = off, 1 = single character equal to register 1, 2 = single character equal to register 2, 3 = register 1 followed by register 2.
- R4: In a single-character mode, a matching character produces a one-cycle pulse on the pause or resume output, one cycle after the strobe. That character is not written to the FIFO.
- R5: In the two-character mode, a byte equal to register 1 is held back and not written. If the next byte equals register 2, a one-cycle pulse follows that byte, and neither byte is written.
- R6: If a held byte is followed by a byte that does not complete its pair, the held byte is written one cycle after the breaking byte's strobe. The breaking byte is then judged as a fresh byte. If it must be written, it is written in the following cycle.
- R7: When one byte satisfies both a pause rule and a resume rule, only the pause pulse is produced.
- R8: A character that matches no enabled rule is written with its value unchanged.
- R9: When bit 4 of the control field is set and bits [3:0] are zero, a character equal to pause-2 sets the special flag one cycle after its strobe. That character is still written to the FIFO.
- R10: Special-character detection has no effect while any bit of control field bits [3:0] is set.
- R11: The special flag stays set until a status read strobe, and is clear from the next cycle on. A special match in the same cycle as the read leaves the flag set.
- R12: Character strobes are at least two cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0..4) |
| cfg_wdata | input | 8 | Register write data |
| rx_valid | input | 1 | Received-character strobe |
| rx_data | input | 8 | Received character |
| status_rd | input | 1 | Interrupt status read strobe, clears the special flag |
| fifo_we | output | 1 | Receive FIFO write strobe |
| fifo_wdata | output | 8 | Receive FIFO write data |
| tx_pause | output | 1 | One-cycle transmit pause request |
| tx_resume | output | 1 | One-cycle transmit resume request |
| spec_flag | output | 1 | Sticky special-character interrupt flag |

## Verification
The bench sweeps all sixteen mode combinations twice. The first pass uses four distinct match characters. The second uses registers where a resume and a pause character coincide. Both passes feed one character stream containing complete pairs, broken pairs, repeated first bytes and plain data.

A design that forgets to write a held byte loses data on a broken pair. One that skips re-judging the breaking byte misses a pair that starts right after a false start. One that drops the spill write, or writes the two bytes in the wrong order, corrupts the FIFO stream. One with the wrong priority pulses resume on a shared character.

The special flag is tested for stickiness, for clearing on a read, for winning against a read in the same cycle, and for having no effect while software flow control is enabled.

// File: rtl/rxfc_pkg.sv
// Package rxfc_pkg: shared encodings for the receive flow-control detector.
// Assumes the control field layout is fixed by the register map in the brief.
package rxfc_pkg;

    // Matching style for one direction (resume or pause)
    typedef enum logic [1:0] {
        FC_OFF     = 2'd0,
        FC_SINGLE1 = 2'd1,
        FC_SINGLE2 = 2'd2,
        FC_DUAL    = 2'd3
    } fc_mode_e;

    // Per-direction comparison result for the current character
    typedef struct packed {
        logic single; // complete match in a single-character mode
        logic first;  // first byte of a two-character pair
        logic second; // second byte of a two-character pair
    } match_t;

    localparam int unsigned ADDR_W       = 3;
    localparam int unsigned ADDR_ON1     = 0;
    localparam int unsigned ADDR_ON2     = 1;
    localparam int unsigned ADDR_OFF1    = 2;
    localparam int unsigned ADDR_OFF2    = 3;
    localparam int unsigned ADDR_CTL     = 4;
    localparam int unsigned CTL_SPEC_BIT = 4;

endpackage

// File: rtl/rxfc_cfg_regs.sv
// Module rxfc_cfg_regs: holds the four match characters and the control
// field. Assumes DATA_W >= 5 so that the control bits fit in one write word.
module rxfc_cfg_regs
    import rxfc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] on1,
    output logic [DATA_W-1:0] on2,
    output logic [DATA_W-1:0] off1,
    output logic [DATA_W-1:0] off2,
    output fc_mode_e          mode_on,
    output fc_mode_e          mode_off,
    output logic              spec_req
);

    // Register file update; all features off after reset (R1, R2)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on1      <= '0;
            on2      <= '0;
            off1     <= '0;
            off2     <= '0;
            mode_on  <= FC_OFF;
            mode_off <= FC_OFF;
            spec_req <= 1'b0;
        end else if (we) begin
            case (addr)
                ADDR_W'(ADDR_ON1):  on1  <= wdata;
                ADDR_W'(ADDR_ON2):  on2  <= wdata;
                ADDR_W'(ADDR_OFF1): off1 <= wdata;
                ADDR_W'(ADDR_OFF2): off2 <= wdata;
                ADDR_W'(ADDR_CTL): begin
                    mode_on  <= fc_mode_e'(wdata[1:0]);
                    mode_off <= fc_mode_e'(wdata[3:2]);
                    spec_req <= wdata[CTL_SPEC_BIT];
                end
                default: ;
            endcase
        end
    end

    // R1: the control field is cleared by reset
    p_reset_off_r1: assert property (@(posedge clk)
        !rst_n |=> (mode_on == FC_OFF && mode_off == FC_OFF && !spec_req));

endmodule

// File: rtl/rxfc_char_match.sv
// Module rxfc_char_match: compares one character with one register pair
// under one direction's mode. Purely combinational.
module rxfc_char_match
    import rxfc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  fc_mode_e          mode,
    input  logic [DATA_W-1:0] reg1,
    input  logic [DATA_W-1:0] reg2,
    input  logic [DATA_W-1:0] data,
    output match_t            hit
);

    logic eq1;
    logic eq2;

    // Bitwise equality, bit 0 against the character LSB (R2)
    always_comb begin
        eq1 = (data == reg1);
        eq2 = (data == reg2);
    end

    // Decode the mode into single, first and second hits (R3)
    always_comb begin
        hit.single = ((mode == FC_SINGLE1) && eq1) || ((mode == FC_SINGLE2) && eq2);
        hit.first  = (mode == FC_DUAL) && eq1;
        hit.second = (mode == FC_DUAL) && eq2;
    end

endmodule

// File: rtl/rxfc_seq.sv
// Module rxfc_seq: decides pulses and FIFO writes per received character.
// It holds back the first byte of a possible pair and spills a second
// write into the next cycle. Assumes strobes are at least two cycles apart.
module rxfc_seq
    import rxfc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  match_t            on_hit,
    input  match_t            off_hit,
    output logic              fifo_we,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              tx_pause,
    output logic              tx_resume
);

    logic              pend_on;
    logic              pend_off;
    logic [DATA_W-1:0] pend_byte;
    logic              spill_v;
    logic [DATA_W-1:0] spill_d;

    logic pend_any;
    logic done_off;
    logic done_on;
    logic fresh_pause;
    logic fresh_resume;
    logic fresh_hold;
    logic fresh_write;
    logic n_pause;
    logic n_resume;
    logic n_wr;
    logic [DATA_W-1:0] n_wd;
    logic n_spill;
    logic n_pon;
    logic n_poff;

    // Judge the current byte as a fresh byte, pause first (R4, R7)
    always_comb begin
        fresh_pause  = off_hit.single;
        fresh_resume = !off_hit.single && on_hit.single;
        fresh_hold   = !off_hit.single && !on_hit.single && (on_hit.first || off_hit.first);
        fresh_write  = !off_hit.single && !on_hit.single && !on_hit.first && !off_hit.first;
    end

    // Combine a held byte with the current byte (R5, R6, R8)
    always_comb begin
        pend_any = pend_on || pend_off;
        done_off = pend_off && off_hit.second;
        done_on  = pend_on && on_hit.second && !done_off;
        n_pause  = 1'b0;
        n_resume = 1'b0;
        n_wr     = 1'b0;
        n_wd     = rx_data;
        n_spill  = 1'b0;
        n_pon    = 1'b0;
        n_poff   = 1'b0;
        if (done_off) begin
            n_pause = 1'b1;
        end else if (done_on) begin
            n_resume = 1'b1;
        end else begin
            n_pause  = fresh_pause;
            n_resume = fresh_resume;
            n_pon    = fresh_hold && on_hit.first;
            n_poff   = fresh_hold && off_hit.first;
            if (pend_any) begin
                n_wr    = 1'b1;
                n_wd    = pend_byte;
                n_spill = fresh_write;
            end else begin
                n_wr = fresh_write;
            end
        end
    end

    // Output, hold and spill registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_on    <= 1'b0;
            pend_off   <= 1'b0;
            pend_byte  <= '0;
            spill_v    <= 1'b0;
            spill_d    <= '0;
            fifo_we    <= 1'b0;
            fifo_wdata <= '0;
            tx_pause   <= 1'b0;
            tx_resume  <= 1'b0;
        end else begin
            fifo_we   <= 1'b0;
            tx_pause  <= 1'b0;
            tx_resume <= 1'b0;
            spill_v   <= 1'b0;
            if (spill_v) begin
                fifo_we    <= 1'b1;
                fifo_wdata <= spill_d;
            end
            if (rx_valid) begin
                tx_pause  <= n_pause;
                tx_resume <= n_resume;
                fifo_we   <= n_wr;
                if (n_wr) begin
                    fifo_wdata <= n_wd;
                end
                spill_v  <= n_spill;
                spill_d  <= rx_data;
                pend_on  <= n_pon;
                pend_off <= n_poff;
                if (n_pon || n_poff) begin
                    pend_byte <= rx_data;
                end
            end
        end
    end

    // R12: input strobes are spaced by at least two cycles
    p_rx_spacing_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R7: never both requests at once
    p_one_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_pause && tx_resume));

    // R4: a request lasts one cycle
    p_pause_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pause |=> !tx_pause);

    // R8: with nothing held, an unmatched byte is written unchanged
    p_passthrough_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !pend_any && fresh_write)
        |=> (fifo_we && fifo_wdata == $past(rx_data)));

    // R5: a completed pair writes nothing in the following cycle
    p_pair_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (done_off || done_on)) |=> !fifo_we);

    // R6: a spilled write follows the held byte's write
    p_spill_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spill_v |-> fifo_we);

endmodule

// File: rtl/rxfc_special.sv
// Module rxfc_special: sticky special-character flag, compared against the
// second pause register. The enable is gated by the caller.
module rxfc_special #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [DATA_W-1:0] ref_char,
    input  logic              status_rd,
    output logic              flag
);

    logic hit;

    // Special match for the current byte (R9)
    always_comb begin
        hit = enable && rx_valid && (rx_data == ref_char);
    end

    // Set wins over a read in the same cycle (R11)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (status_rd) begin
            flag <= 1'b0;
        end
    end

    // R11: the flag holds until a read
    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !status_rd) |=> flag);

    // R11: a read with no new match clears it
    p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !hit) |=> !flag);

    // R9: the flag rises only after a received character
    p_flag_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(rx_valid));

endmodule

// File: rtl/rxfc_detect.sv
// Module rxfc_detect: receive flow-control character detector top level.
// Wires the register file, two direction matchers (index 0 = resume,
// 1 = pause), the sequencer and the special-character flag.
module rxfc_detect
    import rxfc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              status_rd,
    output logic              fifo_we,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              tx_pause,
    output logic              tx_resume,
    output logic              spec_flag
);

    localparam int unsigned NDIR = 2;

    logic [DATA_W-1:0] on1, on2, off1, off2;
    fc_mode_e          mode_on, mode_off;
    logic              spec_req;
    logic              spec_en;

    logic [DATA_W-1:0] pair_r1   [NDIR];
    logic [DATA_W-1:0] pair_r2   [NDIR];
    fc_mode_e          pair_mode [NDIR];
    match_t            hit       [NDIR];

    rxfc_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .on1      (on1),
        .on2      (on2),
        .off1     (off1),
        .off2     (off2),
        .mode_on  (mode_on),
        .mode_off (mode_off),
        .spec_req (spec_req)
    );

    // Route each register pair to its direction slot
    always_comb begin
        pair_r1[0]   = on1;
        pair_r2[0]   = on2;
        pair_mode[0] = mode_on;
        pair_r1[1]   = off1;
        pair_r2[1]   = off2;
        pair_mode[1] = mode_off;
    end

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        rxfc_char_match #(.DATA_W(DATA_W)) u_match (
            .mode (pair_mode[g]),
            .reg1 (pair_r1[g]),
            .reg2 (pair_r2[g]),
            .data (rx_data),
            .hit  (hit[g])
        );
    end

    rxfc_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .on_hit     (hit[0]),
        .off_hit    (hit[1]),
        .fifo_we    (fifo_we),
        .fifo_wdata (fifo_wdata),
        .tx_pause   (tx_pause),
        .tx_resume  (tx_resume)
    );

    // Special detect only while software flow control is fully off (R10)
    always_comb begin
        spec_en = spec_req && (mode_on == FC_OFF) && (mode_off == FC_OFF);
    end

    rxfc_special #(.DATA_W(DATA_W)) u_spec (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (spec_en),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .ref_char  (off2),
        .status_rd (status_rd),
        .flag      (spec_flag)
    );

    // R10: no flag rise while a flow-control mode is active
    p_spec_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (mode_on != FC_OFF || mode_off != FC_OFF) && !spec_flag)
        |=> !spec_flag);

endmodule

// File: tb/rxfc_detect_tb.sv
module rxfc_detect_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       status_rd = 1'b0;
    logic       fifo_we;
    logic [7:0] fifo_wdata;
    logic       tx_pause;
    logic       tx_resume;
    logic       spec_flag;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;

    // Reference state, built from the requirements
    logic [7:0] m_x [4];
    logic [4:0] m_ctl = '0;
    bit         m_pend = 0, m_pon = 0, m_poff = 0, m_flag = 0;
    logic [7:0] m_pb = '0;

    logic [7:0] seq_b [17] = '{8'h11, 8'h13, 8'h93, 8'h95, 8'h41, 8'h11, 8'h42,
                              8'h11, 8'h11, 8'h13, 8'h93, 8'h11, 8'h13, 8'h93,
                              8'h95, 8'h13, 8'h43};

    always #4 clk = ~clk; // 125 MHz

    rxfc_detect dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .status_rd(status_rd), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata),
        .tx_pause(tx_pause), .tx_resume(tx_resume), .spec_flag(spec_flag)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (ctl %0h)", tag, what, act, exp, m_ctl);
        end
    endtask

    function automatic bit sgl(input logic [1:0] md, input logic [7:0] b,
                               input logic [7:0] r1, input logic [7:0] r2);
        return (md == 2'd1 && b == r1) || (md == 2'd2 && b == r2);
    endfunction

    task automatic wcfg(input int a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 4) m_x[a] = d; else m_ctl = d[4:0];
    endtask

    // Send one character, compare both following cycles with the model
    task automatic send(input logic [7:0] b, input bit rd);
        logic [1:0] mon = m_ctl[1:0];
        logic [1:0] moff = m_ctl[3:2];
        bit e_p = 0, e_r = 0, e_w1 = 0, e_w2 = 0;
        logic [7:0] e_d1 = '0, e_d2 = '0;
        bit fs_off = sgl(moff, b, m_x[2], m_x[3]);
        bit fs_on  = sgl(mon, b, m_x[0], m_x[1]);
        bit ff_off = (moff == 2'd3) && (b == m_x[2]);
        bit ff_on  = (mon == 2'd3) && (b == m_x[0]);
        if (m_pend && m_poff && moff == 2'd3 && b == m_x[3]) begin
            e_p = 1; m_pend = 0;
        end else if (m_pend && m_pon && mon == 2'd3 && b == m_x[1]) begin
            e_r = 1; m_pend = 0;
        end else begin
            bit had = m_pend;
            if (had) begin e_w1 = 1; e_d1 = m_pb; end
            m_pend = 0;
            if (fs_off) e_p = 1;
            else if (fs_on) e_r = 1;
            else if (ff_on || ff_off) begin
                m_pend = 1; m_pon = ff_on; m_poff = ff_off; m_pb = b;
            end else if (had) begin e_w2 = 1; e_d2 = b; end
            else begin e_w1 = 1; e_d1 = b; end
        end
        if (m_ctl[4] && m_ctl[3:0] == 4'd0 && b == m_x[3]) m_flag = 1;
        else if (rd) m_flag = 0;

        rx_valid = 1'b1; rx_data = b; status_rd = rd;
        @(negedge clk);
        rx_valid = 1'b0; status_rd = 1'b0;
        chk(tx_pause == e_p, "R4/R5/R7", "pause", tx_pause, e_p);
        chk(tx_resume == e_r, "R4/R5/R7", "resume", tx_resume, e_r);
        chk(fifo_we == e_w1, "R5/R6/R8", "write1", fifo_we, e_w1);
        if (e_w1) chk(fifo_wdata == e_d1, "R6/R8", "data1", fifo_wdata, e_d1);
        chk(spec_flag == m_flag, "R9/R10/R11", "flag", spec_flag, m_flag);
        @(negedge clk);
        chk(fifo_we == e_w2, "R6", "write2", fifo_we, e_w2);
        if (e_w2) chk(fifo_wdata == e_d2, "R6", "data2", fifo_wdata, e_d2);
        chk(!tx_pause && !tx_resume, "R4", "pulse width", {tx_pause, tx_resume}, 0);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m_x[i] = '0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!fifo_we && !tx_pause && !tx_resume && !spec_flag, "R1", "reset outputs",
            {fifo_we, tx_pause, tx_resume, spec_flag}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: a zero character equals all zero registers but is still written
        send(8'h00, 0);
        // R2: program the match registers
        wcfg(0, 8'h11); wcfg(1, 8'h13); wcfg(3, 8'h95);
        for (int set = 0; set < 2; set++) begin
            wcfg(2, (set == 0) ? 8'h93 : 8'h11);  // set 1 shares a character for R7
            for (int c = 0; c < 16; c++) begin
                wcfg(4, 8'(c));                   // R3: every mode pair
                for (int k = 0; k < 17; k++) send(seq_b[k], 0);
            end
        end
        // R9, R11: special detect
        wcfg(2, 8'h93);
        wcfg(4, 8'h10);
        send(8'h95, 0);
        send(8'h41, 0);
        send(8'h95, 1);   // R11: a match wins over a same-cycle read
        send(8'h41, 1);   // R11: a read clears
        send(8'h41, 0);
        send(8'h95, 0);
        send(8'h41, 1);
        // R10: special ignored while the pause mode is on
        wcfg(4, 8'h14);
        send(8'h95, 0);
        send(8'h95, 0);
        wcfg(4, 8'h11);
        send(8'h95, 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule